// File: doc/BRIEF.md
# Decimating Six-Channel Word Loader

This block turns one narrow stream of 10-bit words into six parallel channel codes. Words arrive one per active clock edge. A start strobe opens a loading run of six words, and a direction select sets which end of the channel row is filled first. The active edge is chosen at run time: rising edges or falling edges. The six captured words sit in a first register bank until a transfer strobe copies the whole bank into a second, output-facing bank in one step. A new line can therefore load while the previous six codes stay steady at the outputs.

The output bank feeds six converter inputs elsewhere on the chip. A polarity input selects whether each code is presented as is or mirrored about full scale. A standby input wipes both banks and the loading state. A one-edge pulse marks the capture of the last word of a run, so a line sequencer can schedule the transfer.

Top module: `dec_loader`

## Requirements
- R1: With `edgeRise` high, data and the start strobe are sampled on rising `clk` edges. With it low, they are sampled on falling edges. `edgeRise` is changed only while reset is held.
- R2: A loading run begins on an active edge only if `startSeq` was high at the previous active edge. The first word of the run is captured on that same edge.
- R3: With `dirUp` high, the words of a run fill channels 0,1,2,3,4,5 in that order. With it low, they fill 5,4,3,2,1,0. Channel i is `codesOut[10*i+9:10*i]`.
- R4: Once six words are captured, and at any time outside a run, the words on `dataIn` are ignored until the next valid start.
- R5: If `xferReq` is high at a rising edge, all six first-bank words are copied into the output bank at the next falling edge. Without such a request the output bank holds.
- R6: Loading into the first bank never changes `codesOut` without a transfer.
- R7: With `invertPol` high, each channel shows 1023 − n; with it low, it shows the stored code n. `polarityOut` equals `invertPol`.
- R8: While `standby` is high, both banks, the run counter and the pending start are cleared at each clock edge of their domain. After `standby` falls, no word loads until a new start is seen.
- R9: An asynchronous active-low `rstN` clears both banks, the run state, the pending transfer and `lineLoaded`.
- R10: `lineLoaded` goes high for exactly one active-edge period after the edge that captures the sixth word of a run.
- R11: A transfer requested part way through a run copies the first bank as it stands at the copying falling edge. Channels already reached hold new words; the rest hold their older contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | 10 | Input word, bit 9 most significant |
| startSeq | input | 1 | Start strobe, acts one active edge later |
| edgeRise | input | 1 | 1 = rising active edge, 0 = falling |
| dirUp | input | 1 | 1 = fill 0→5, 0 = fill 5→0 |
| xferReq | input | 1 | Transfer request, sampled on rising edges |
| invertPol | input | 1 | Output polarity mirror |
| standby | input | 1 | Synchronous clear of all stored state |
| codesOut | output | 60 | Six output codes, channel i at bits 10*i+9:10*i |
| polarityOut | output | 1 | Polarity flag that travels with the codes |
| lineLoaded | output | 1 | One-period pulse after the sixth word |

## Verification
A start shows its effect two active edges after it is driven: the pending flag is set on the first edge, and the first word is captured on the second. The bench sets each value in the half period that ends at the active edge and replaces it with a filler word right after. Sampling on the wrong edge would then pick up filler. A transfer is asserted for one rising edge, and the codes are read one nanosecond after the following falling edge. For a transfer in the middle of a run, the bench works out how many words the first bank already holds at that falling edge, for each edge choice, and predicts the mixed contents from that count. `lineLoaded` is read just after the edge that takes the sixth word and again one active edge later.

// File: rtl/dec_loader_pkg.sv
package dec_loader_pkg;
  parameter int NUM_CH = 6;
  parameter int SLOT_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  // control-to-datapath strobes
  typedef struct packed {
    logic              wrEn;
    logic [SLOT_W-1:0] wrSlot;
    logic              copyEn;
  } strobe_t;
endpackage

// File: rtl/dec_loader_ctrl.sv
module dec_loader_ctrl
  import dec_loader_pkg::*;
(
  input  logic    clk,
  input  logic    loadClk,
  input  logic    rstN,
  input  logic    startSeq,
  input  logic    dirUp,
  input  logic    xferReq,
  input  logic    standby,
  output strobe_t strobes,
  output logic    lineLoaded
);
  localparam logic [SLOT_W-1:0] LAST_POS = SLOT_W'(NUM_CH - 1);

  logic [SLOT_W-1:0] runPos;   // position of the next word; 0 while idle
  logic              running;
  logic              armed;
  logic              lineDone;
  logic              xfrSeen;
  logic [SLOT_W-1:0] pos;

  always_comb pos = armed ? '0 : runPos;

  assign strobes.wrEn   = !standby && (armed || running);
  assign strobes.wrSlot = dirUp ? pos : (LAST_POS - pos);
  assign strobes.copyEn = xfrSeen;
  assign lineLoaded     = lineDone;

  // sequence state, clocked on the selected active edge
  always_ff @(posedge loadClk or negedge rstN) begin
    if (!rstN) begin
      runPos   <= '0;
      running  <= 1'b0;
      armed    <= 1'b0;
      lineDone <= 1'b0;
    end else if (standby) begin
      runPos   <= '0;
      running  <= 1'b0;
      armed    <= 1'b0;
      lineDone <= 1'b0;
    end else begin
      armed    <= startSeq;
      lineDone <= 1'b0;
      if (armed) begin
        if (NUM_CH == 1) begin
          running  <= 1'b0;
          lineDone <= 1'b1;
        end else begin
          runPos  <= SLOT_W'(1);
          running <= 1'b1;
        end
      end else if (running) begin
        if (runPos == LAST_POS) begin
          runPos   <= '0;
          running  <= 1'b0;
          lineDone <= 1'b1;
        end else begin
          runPos <= runPos + SLOT_W'(1);
        end
      end
    end
  end

  // transfer request seen on a rising edge, acted on at the next falling edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        xfrSeen <= 1'b0;
    else if (standby) xfrSeen <= 1'b0;
    else              xfrSeen <= xferReq;
  end

  assert_slot_range_R3: assert property (@(posedge loadClk) disable iff (!rstN)
    strobes.wrEn |-> (strobes.wrSlot <= LAST_POS));

  assert_first_slot_R2: assert property (@(posedge loadClk) disable iff (!rstN)
    (armed && !standby) |-> (strobes.wrSlot == (dirUp ? '0 : LAST_POS)));

  assert_single_pulse_R10: assert property (@(posedge loadClk) disable iff (!rstN)
    lineLoaded |=> !lineLoaded);

  assert_standby_idle_R8: assert property (@(posedge loadClk) disable iff (!rstN)
    standby |=> (!running && !armed && !lineLoaded));

  assert_no_copy_in_standby_R8: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> !strobes.copyEn);
endmodule

// File: rtl/dec_loader_datapath.sv
module dec_loader_datapath
  import dec_loader_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic                     clk,
  input  logic                     loadClk,
  input  logic                     rstN,
  input  logic [DATA_W-1:0]        dataIn,
  input  logic                     invertPol,
  input  logic                     standby,
  input  strobe_t                  ctl,
  output logic [NUM_CH*DATA_W-1:0] codesOut
);
  localparam int FLAT_W = NUM_CH * DATA_W;

  logic [DATA_W-1:0] stage1 [NUM_CH];
  logic [DATA_W-1:0] held   [NUM_CH];
  logic [FLAT_W-1:0] stage1Flat;
  logic [FLAT_W-1:0] heldFlat;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    // first bank: written on the active edge when this channel is addressed
    always_ff @(posedge loadClk or negedge rstN) begin
      if (!rstN)        stage1[ch] <= '0;
      else if (standby) stage1[ch] <= '0;
      else if (ctl.wrEn && (ctl.wrSlot == SLOT_W'(ch))) stage1[ch] <= dataIn;
    end

    // output bank: copied together on a falling edge
    always_ff @(negedge clk or negedge rstN) begin
      if (!rstN)           held[ch] <= '0;
      else if (standby)    held[ch] <= '0;
      else if (ctl.copyEn) held[ch] <= stage1[ch];
    end

    assign stage1Flat[ch*DATA_W +: DATA_W] = stage1[ch];
    assign heldFlat[ch*DATA_W +: DATA_W]   = held[ch];
    // mirror about full scale: (2^W - 1) - n equals bitwise complement
    assign codesOut[ch*DATA_W +: DATA_W]   = held[ch] ^ {DATA_W{invertPol}};
  end

  assert_write_lands_R3: assert property (@(posedge loadClk) disable iff (!rstN)
    ctl.wrEn |=> (stage1Flat[$past(ctl.wrSlot)*DATA_W +: DATA_W] == $past(dataIn)));

  assert_copy_whole_bank_R5: assert property (@(negedge clk) disable iff (!rstN)
    (ctl.copyEn && !standby) |=> (heldFlat == $past(stage1Flat)));

  assert_hold_without_copy_R6: assert property (@(negedge clk) disable iff (!rstN)
    (!ctl.copyEn && !standby) |=> $stable(heldFlat));

  assert_standby_clear_R8: assert property (@(negedge clk) disable iff (!rstN)
    standby |=> (heldFlat == '0));
endmodule

// File: rtl/dec_loader.sv
module dec_loader
  import dec_loader_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [DATA_W-1:0]        dataIn,
  input  logic                     startSeq,
  input  logic                     edgeRise,
  input  logic                     dirUp,
  input  logic                     xferReq,
  input  logic                     invertPol,
  input  logic                     standby,
  output logic [NUM_CH*DATA_W-1:0] codesOut,
  output logic                     polarityOut,
  output logic                     lineLoaded
);
  strobe_t strobes;
  logic    loadClk;

  // active-edge select: the loading domain runs on clk or its complement
  assign loadClk     = edgeRise ? clk : ~clk;
  assign polarityOut = invertPol;

  dec_loader_ctrl i_ctrl (
    .clk        (clk),
    .loadClk    (loadClk),
    .rstN       (rstN),
    .startSeq   (startSeq),
    .dirUp      (dirUp),
    .xferReq    (xferReq),
    .standby    (standby),
    .strobes    (strobes),
    .lineLoaded (lineLoaded)
  );

  dec_loader_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk       (clk),
    .loadClk   (loadClk),
    .rstN      (rstN),
    .dataIn    (dataIn),
    .invertPol (invertPol),
    .standby   (standby),
    .ctl       (strobes),
    .codesOut  (codesOut)
  );
endmodule

// File: tb/test_dec_loader.sv
module test_dec_loader;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;
  localparam int DW = 10;
  localparam logic [DW-1:0] FILLER = 10'h3FF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic startSeq = 1'b0, edgeRise = 1'b1, dirUp = 1'b1;
  logic xferReq = 1'b0, invertPol = 1'b0, standby = 1'b0;
  logic [NCH*DW-1:0] codesOut;
  logic polarityOut, lineLoaded;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_loader i_dec_loader (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .startSeq(startSeq),
    .edgeRise(edgeRise), .dirUp(dirUp), .xferReq(xferReq),
    .invertPol(invertPol), .standby(standby), .codesOut(codesOut),
    .polarityOut(polarityOut), .lineLoaded(lineLoaded)
  );

  function automatic logic [DW-1:0] wordOf(int seed, int k);
    return DW'((k * 97 + seed * 211 + 5) % 1000);
  endfunction

  function automatic int slotOf(logic d, int k);
    return d ? k : (NCH - 1 - k);
  endfunction

  // full line of a seed laid out according to the fill direction
  function automatic logic [NCH*DW-1:0] lineOf(int seed, logic d);
    logic [NCH*DW-1:0] v = '0;
    for (int k = 0; k < NCH; k++) v[slotOf(d, k)*DW +: DW] = wordOf(seed, k);
    return v;
  endfunction

  task automatic check(string req, logic [NCH*DW-1:0] act, logic [NCH*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic waitActive();
    if (edgeRise) @(posedge clk); else @(negedge clk);
  endtask

  task automatic waitOpposite();
    if (edgeRise) @(negedge clk); else @(posedge clk);
  endtask

  // one run of six words; values are valid only in the half period before the
  // active edge. xfrAt >= 0 raises the transfer request after that many captures.
  task automatic runSeq(int seed, int xfrAt, bit checkLine);
    for (int e = 0; e <= 8; e++) begin
      waitActive();
      #1;
      dataIn = FILLER;
      startSeq = 1'b0;
      xferReq = (xfrAt >= 0) && (e == xfrAt + 1);
      if (checkLine && e == 7) checkBit("R10 pulse after sixth word", lineLoaded, 1'b1);
      if (checkLine && e == 8) checkBit("R10 pulse one period only", lineLoaded, 1'b0);
      waitOpposite();
      #1;
      if (e == 0) startSeq = 1'b1;
      else if (e >= 1 && e <= NCH) dataIn = wordOf(seed, e - 1);
    end
    xferReq = 1'b0;
  endtask

  task automatic feedNoStart(int n);
    for (int e = 0; e < n; e++) begin
      waitOpposite();
      #1 dataIn = DW'(e * 131 + 17);
      waitActive();
      #1 dataIn = FILLER;
    end
  endtask

  task automatic doTransfer();
    @(negedge clk); #1 xferReq = 1'b1;
    @(posedge clk); #1 xferReq = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    #(CLK_PERIOD * 2);
    @(negedge clk); #2 rstN = 1'b1;
  endtask

  initial begin
    for (int cfg = 0; cfg < 4; cfg++) begin
      logic [NCH*DW-1:0] full, mixed;
      int m;
      edgeRise = cfg[0];
      dirUp = cfg[1];
      doReset();
      check("R9 reset codes", codesOut, '0);
      checkBit("R9 reset pulse", lineLoaded, 1'b0);

      // R1 R2 R10: full run, output bank untouched until transfer (R6)
      runSeq(cfg * 2, -1, 1'b1);
      check("R6 codes unchanged by loading", codesOut, '0);
      doTransfer();
      full = lineOf(cfg * 2, dirUp);
      check("R1 R2 R3 R5 full line after transfer", codesOut, full);

      // R7 polarity mirror
      invertPol = 1'b1; #1;
      check("R7 inverted codes", codesOut, ~full);
      checkBit("R7 polarity flag high", polarityOut, 1'b1);
      invertPol = 1'b0; #1;
      check("R7 raw codes", codesOut, full);
      checkBit("R7 polarity flag low", polarityOut, 1'b0);

      // R4 words outside a run are ignored
      feedNoStart(8);
      doTransfer();
      check("R4 words without start ignored", codesOut, full);

      // R11 transfer in the middle of a run
      runSeq(cfg * 2 + 1, 3, 1'b0);
      m = 3 + (edgeRise ? 1 : 0);
      mixed = full;
      for (int k = 0; k < m; k++)
        mixed[slotOf(dirUp, k)*DW +: DW] = wordOf(cfg * 2 + 1, k);
      check("R11 partial contents copied", codesOut, mixed);
      doTransfer();
      check("R3 second line after transfer", codesOut, lineOf(cfg * 2 + 1, dirUp));

      // R8 standby clears, no load until a new start
      standby = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check("R8 standby clears outputs", codesOut, '0);
      @(negedge clk); #1 standby = 1'b0;
      feedNoStart(8);
      doTransfer();
      check("R8 nothing loads after standby", codesOut, '0);
      runSeq(cfg + 20, -1, 1'b1);
      doTransfer();
      check("R8 new start loads again", codesOut, lineOf(cfg + 20, dirUp));

      // R9 asynchronous reset clears at once
      #2 rstN = 1'b0; #1;
      check("R9 async reset clears", codesOut, '0);
      rstN = 1'b1;
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule